// File: doc/BRIEF.md
# CRC16/CRC32 Register-Mapped Accelerator

This peripheral computes a running CRC over data that software writes into it through a small synchronous register interface. A control register selects one of two polynomial modes (16-bit or 32-bit), the order in which the bits of each data write are consumed, and whether the engine runs at all. Software may seed the running checksum by writing a preload register. It then streams data into one of three data offsets. The offset that is written sets how many bits are folded in: 32, 16 or 8.

Each data write is absorbed in the clock cycle in which it is presented. The updated checksum is visible at the result offset on the next access. Reads are combinational from the registers. Writes take effect at the clock edge on which `bus_valid` and `bus_write` are both high.

Top module: `crc_accel`

## Requirements
- R1: After reset, the result offset (0x10) reads 0x0000FFFF. Control (0x00), the three data offsets and preload (0x14) read 0.
- R2: Control holds only a 3-bit mode field at bits [6:4], a bit-order flag at bit 2 and an enable at bit 0. All other control bits read 0 whatever is written. Offsets 0x04, 0x08, 0x0C and 0x14 read back the last full 32-bit value written to them.
- R3: A write to preload (0x14) replaces the running state with the written value. This happens regardless of the enable and the mode, and later data continues from that value.
- R4: Mode value 0 selects a 16-bit CRC with polynomial 0x1021, which runs on state bits [15:0]. Each such update clears state bits [31:16]. While the mode is 0, the result reads with bits [31:16] equal to 0.
- R5: Mode value 1 selects a 32-bit CRC with polynomial 0x04C11DB7 over the whole state. No output reflection and no final XOR are applied, so the result reads the raw state.
- R6: A data write folds in bits [31:0] at offset 0x04, bits [15:0] at 0x08 and bits [7:0] at 0x0C. Data bits above the folded width have no effect on the result.
- R7: Bit 2 of control set to 0 folds the selected bits from the highest index down. Set to 1, it folds them from bit 0 upward.
- R8: While enable (bit 0) is 0, data writes leave the result unchanged.
- R9: While the mode field holds any value from 2 to 7, data writes leave the result unchanged.
- R10: Writes to the result offset or to any unmapped offset leave every register unchanged. Reads of unmapped offsets return 0.
- R11: A data write that is accepted at a clock edge is fully reflected in the result read in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed offset |

## Verification
The hardest case to reach is a change of polynomial mode in the middle of a stream. This matters most when the state still carries upper bits from a 32-bit preload or update, because a 16-bit update must then discard those bits. The same applies to data writes that arrive while the mode field holds a reserved value. The stimulus gets there through long random traffic in which control writes are mixed in among preloads and data writes of every width. Most control writes keep the mode at 0 or 1 and the engine enabled, and a minority reach reserved modes or clear the enable. A behavioural bit-queue model is compared against the result after every write. Known check values for the standard "123456789" string, and bit-reversal and width-splitting equivalences, pin the arithmetic independently of the model.

// File: rtl/crc_accel.sv
module crc_accel #(
  parameter int          ADDR_W = 8,
  parameter logic [15:0] POLY16 = 16'h1021,
  parameter logic [31:0] POLY32 = 32'h04C1_1DB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_W32  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_W16  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFS_W8   = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] OFS_SUM  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFS_SEED = ADDR_W'('h14);
  localparam logic [31:0]       SUM_RST  = 32'h0000_FFFF;

  logic [2:0]  mode_q;
  logic        lsb_q;
  logic        run_q;
  logic [31:0] w32_q, w16_q, w8_q, seed_q, sum_q;

  logic        wr, rd, is_feed, mode_ok, wide;
  logic [5:0]  feed_bits;
  logic [31:0] sum_next;

  assign wr      = bus_valid & bus_write;
  assign rd      = bus_valid & ~bus_write;
  assign mode_ok = (mode_q == 3'd0) || (mode_q == 3'd1);
  assign wide    = (mode_q == 3'd1);
  assign is_feed = (bus_addr == OFS_W32) || (bus_addr == OFS_W16) || (bus_addr == OFS_W8);

  always_comb begin
    case (bus_addr)
      OFS_W32: feed_bits = 6'd32;
      OFS_W16: feed_bits = 6'd16;
      OFS_W8:  feed_bits = 6'd8;
      default: feed_bits = 6'd0;
    endcase
  end

  function automatic logic [31:0] fold(input logic [31:0] st, input logic [31:0] d,
                                       input logic [5:0] nb, input logic lsb, input logic w32);
    logic [31:0] s;
    logic [4:0]  idx;
    logic        b;
    s = st;
    for (int i = 0; i < 32; i++) begin
      if (i < int'(nb)) begin
        idx = lsb ? 5'(i) : 5'(int'(nb) - 1 - i);
        b   = d[idx];
        if (w32)
          s = {s[30:0], 1'b0} ^ ((s[31] ^ b) ? POLY32 : 32'h0);
        else
          s = {16'h0, s[14:0], 1'b0} ^ ((s[15] ^ b) ? {16'h0, POLY16} : 32'h0);
      end
    end
    return s;
  endfunction

  assign sum_next = fold(sum_q, bus_wdata, feed_bits, lsb_q, wide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      lsb_q  <= 1'b0;
      run_q  <= 1'b0;
      w32_q  <= '0;
      w16_q  <= '0;
      w8_q   <= '0;
      seed_q <= '0;
      sum_q  <= SUM_RST;
    end else if (wr) begin
      case (bus_addr)
        OFS_CTRL: begin
          mode_q <= bus_wdata[6:4];
          lsb_q  <= bus_wdata[2];
          run_q  <= bus_wdata[0];
        end
        OFS_W32:  w32_q <= bus_wdata;
        OFS_W16:  w16_q <= bus_wdata;
        OFS_W8:   w8_q  <= bus_wdata;
        OFS_SEED: begin
          seed_q <= bus_wdata;
          sum_q  <= bus_wdata;
        end
        default: ;
      endcase
      if (is_feed && run_q && mode_ok)
        sum_q <= sum_next;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL: bus_rdata = {25'h0, mode_q, 1'b0, lsb_q, 1'b0, run_q};
      OFS_W32:  bus_rdata = w32_q;
      OFS_W16:  bus_rdata = w16_q;
      OFS_W8:   bus_rdata = w8_q;
      OFS_SUM:  bus_rdata = (mode_q == 3'd0) ? {16'h0, sum_q[15:0]} : sum_q;
      OFS_SEED: bus_rdata = seed_q;
      default:  bus_rdata = 32'h0;
    endcase
  end

  // R3
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFS_SEED) |=> (sum_q == $past(bus_wdata)));

  // R8
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && is_feed && !run_q) |=> $stable(sum_q));

  // R9
  bad_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && is_feed && !mode_ok) |=> $stable(sum_q));

  // R10
  stray_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !is_feed && bus_addr != OFS_SEED) |=> $stable(sum_q));

  // R4
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == OFS_SUM && mode_q == 3'd0) |-> (bus_rdata[31:16] == 16'h0));

  // R2
  ctrl_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == OFS_CTRL) |-> (bus_rdata[31:7] == 25'h0 && !bus_rdata[3] && !bus_rdata[1]));

endmodule

// File: tb/crc_accel_tb_top.sv
`timescale 1ns/1ps
module crc_accel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0, errors = 0;

  logic [31:0] m_ctrl = 0, m_w32 = 0, m_w16 = 0, m_w8 = 0, m_seed = 0, m_sum = 32'h0000FFFF;

  always #2.5 clk = ~clk;

  crc_accel dut_i (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
                   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] st, input logic [31:0] d,
                                          input int n, input bit lsb, input bit w32);
    bit q[$];
    longint unsigned v, poly, mask;
    int w;
    w    = w32 ? 32 : 16;
    poly = w32 ? 64'h04C11DB7 : 64'h1021;
    mask = (64'd1 << w) - 1;
    if (lsb) for (int k = 0; k < n; k++) q.push_back(d[k]);
    else     for (int k = n - 1; k >= 0; k--) q.push_back(d[k]);
    v = st & mask;
    while (q.size() > 0) begin
      bit b;
      bit top;
      b = q.pop_front();
      v = v << 1;
      top = v[w];
      v = v & mask;
      if (top ^ b) v = v ^ poly;
    end
    return 32'(v);
  endfunction

  function automatic logic [31:0] ref_read(input logic [7:0] a);
    case (a)
      8'h00: return m_ctrl;
      8'h04: return m_w32;
      8'h08: return m_w16;
      8'h0C: return m_w8;
      8'h10: return (m_ctrl[6:4] == 0) ? (m_sum & 32'hFFFF) : m_sum;
      8'h14: return m_seed;
      default: return 32'h0;
    endcase
  endfunction

  task automatic ref_write(input logic [7:0] a, input logic [31:0] d);
    int n;
    n = (a == 8'h04) ? 32 : (a == 8'h08) ? 16 : (a == 8'h0C) ? 8 : 0;
    case (a)
      8'h00: m_ctrl = d & 32'h75;
      8'h04: m_w32 = d;
      8'h08: m_w16 = d;
      8'h0C: m_w8 = d;
      8'h14: begin m_seed = d; m_sum = d; end
      default: ;
    endcase
    if (n > 0 && m_ctrl[0] && m_ctrl[6:4] <= 1)
      m_sum = ref_crc(m_sum, d, n, m_ctrl[2], m_ctrl[6:4] == 1);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    ref_write(a, d);
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string req, output logic [31:0] got);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1;
    got = bus_rdata;
    check(req, got, ref_read(a));
    @(posedge clk);
  endtask

  task automatic feed_str(input logic [7:0] a);
    string s = "123456789";
    for (int i = 0; i < s.len(); i++) wr(a, 32'(s[i]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [31:0] r, r1, r2;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1 reset values
    rd(8'h10, "R1", r); check("R1", r, 32'h0000FFFF);
    rd(8'h00, "R1", r); check("R1", r, 0);
    rd(8'h04, "R1", r); rd(8'h08, "R1", r); rd(8'h0C, "R1", r);
    rd(8'h14, "R1", r); check("R1", r, 0);
    // R2 control spare bits
    wr(8'h00, 32'hFFFFFFFF);
    rd(8'h00, "R2", r); check("R2", r, 32'h00000075);
    wr(8'h04, 32'hDEADBEEF); rd(8'h04, "R2", r); check("R2", r, 32'hDEADBEEF);
    // R4 R6 R11 16-bit known value from reset seed
    wr(8'h00, 32'h01);
    wr(8'h14, 32'h0000FFFF);
    feed_str(8'h0C);
    rd(8'h10, "R4", r); check("R4", r, 32'h000029B1);
    // R5 R3 32-bit known value
    wr(8'h00, 32'h11);
    wr(8'h14, 32'hFFFFFFFF);
    rd(8'h10, "R3", r); check("R3", r, 32'hFFFFFFFF);
    feed_str(8'h0C);
    rd(8'h10, "R5", r); check("R5", r, 32'h0376E6E7);
    // R8 disabled
    wr(8'h00, 32'h10);
    wr(8'h04, 32'h12345678);
    rd(8'h10, "R8", r); check("R8", r, 32'h0376E6E7);
    // R9 reserved mode
    wr(8'h00, 32'h21);
    wr(8'h08, 32'h0000ABCD);
    wr(8'h00, 32'h11);
    rd(8'h10, "R9", r); check("R9", r, 32'h0376E6E7);
    // R10 ignored writes and unmapped reads
    wr(8'h10, 32'h0);
    wr(8'h18, 32'hFFFFFFFF);
    wr(8'h05, 32'hFFFFFFFF);
    rd(8'h10, "R10", r); check("R10", r, 32'h0376E6E7);
    rd(8'h18, "R10", r); check("R10", r, 0);
    rd(8'h05, "R10", r); check("R10", r, 0);
    rd(8'h00, "R10", r); check("R10", r, 32'h11);
    // R7 bit order: lsb-first 0x01 equals msb-first 0x80
    wr(8'h00, 32'h15); wr(8'h14, 32'hA5A51234); wr(8'h0C, 32'h01);
    rd(8'h10, "R7", r1);
    wr(8'h00, 32'h11); wr(8'h14, 32'hA5A51234); wr(8'h0C, 32'h80);
    rd(8'h10, "R7", r2);
    check("R7", r1, r2);
    // R6 upper bits ignored; 32-bit equals two 16-bit halves
    wr(8'h14, 32'h1); wr(8'h08, 32'hABCD5678); rd(8'h10, "R6", r1);
    wr(8'h14, 32'h1); wr(8'h08, 32'h00005678); rd(8'h10, "R6", r2);
    check("R6", r1, r2);
    wr(8'h14, 32'h77); wr(8'h04, 32'hCAFE1234); rd(8'h10, "R6", r1);
    wr(8'h14, 32'h77); wr(8'h08, 32'h0000CAFE); wr(8'h08, 32'h00001234); rd(8'h10, "R6", r2);
    check("R6", r1, r2);
    // R4 mode switch with upper state bits present
    wr(8'h14, 32'hFFFF0000); wr(8'h00, 32'h01); wr(8'h0C, 32'h5A);
    wr(8'h00, 32'h11);
    rd(8'h10, "R4", r); check("R4", r[31:16], 0);
    // R11 random traffic against model
    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  addrs[8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h05};
      logic [7:0]  a;
      logic [31:0] d;
      a = addrs[$urandom % 8];
      d = $urandom;
      if (a == 8'h00) begin
        if ($urandom % 4 != 0) d[6:5] = 2'b00;
        if ($urandom % 5 != 0) d[0] = 1'b1;
      end
      if ($urandom % 3 == 0) rd(a, "R11", r);
      else begin
        wr(a, d);
        rd(8'h10, "R11", r);
      end
    end
    report();
    $finish;
  end
endmodule